// File: doc/BRIEF.md
# Floating Input Detector with Oscillating Hold Loop

This block tells whether an input pin is driven low, driven high, or left floating. It uses two pins. Each clock cycle it synchronizes the sensed input and registers the inverse of the synchronized sample onto a feedback pin. The board returns that feedback pin to the sense pin through a resistor. A pin that nothing else drives is pulled to the opposite of its last sampled value, so the loop turns into a free-running toggle. A pin that a stronger source drives keeps that source's level.

The classifier watches the synchronized samples. It reports a steady level once the samples have stayed the same for `RUN_LEN` cycles in a row. It reports floating once `RUN_LEN` consecutive samples each equal the inverse of the sample taken one loop latency earlier. The loop latency is `SYNC_STAGES + 1` cycles, so a floating pin flips every loop latency. A deasserted enable releases the feedback pin through its output-enable and marks the result invalid.

Top module: `float_sense_top`

## Requirements
- R1: While enabled, `fb_oe` is 1 and `fb_out` equals the inverse of the synchronized sample from the previous cycle. For a pin held high, `fb_out` settles at 0. For a pin held low, it settles at 1.
- R2: When the sense pin follows `fb_out` (floating pin), `fb_out` changes state once every `SYNC_STAGES + 1` cycles.
- R3: A floating pin is reported as `res_valid` = 1 with `res_code` = 2'b10.
- R4: A pin driven low is reported as `res_code` = 2'b00 and a pin driven high as 2'b01, each with `res_valid` = 1.
- R5: `res_valid` stays 0 until `RUN_LEN` consecutive samples match one of the two patterns after enable.
- R6: A sample that breaks the current pattern clears `res_valid`. An input that fits neither pattern, such as the repeating sequence 1,1,0,1, never sets `res_valid`.
- R7: While `en` is 0, or during reset, `fb_oe` is 0 and `res_valid` is 0. Both follow `en` one cycle later.
- R8: `res_code` never takes the value 2'b11 while `res_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables the feedback drive and the classification |
| pin_in | input | 1 | Sensed pin, asynchronous |
| fb_out | output | 1 | Feedback level, the inverse of the last synchronized sample |
| fb_oe | output | 1 | Output-enable for the feedback pin driver |
| res_valid | output | 1 | The result code is meaningful |
| res_code | output | 2 | 00 low, 01 high, 10 floating |

## Verification
The embedded assertions check on every cycle that the feedback output is the inverse of the previous sample, and that the output-enable and validity follow the enable. They also check that a reported level equals the sample it came from, that a floating result is backed by a full run count, and that the unused code never appears.

Only the bench scenarios can show the closed-loop behaviour. The bench models the resistor by letting the sense pin follow the feedback pin, so it can show that the loop toggles and is classified as floating. It also shows that driven levels win over the feedback, and that an irregular driven sequence never produces a result.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_HIGH  = 2'b01,
    LVL_FLOAT = 2'b10
  } lvl_e;
endpackage

// File: rtl/fsd_sync.sv
module fsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fsd_fb_drive.sv
module fsd_fb_drive (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sample,
  output logic fb_out,
  output logic fb_oe
);
  logic fb_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      fb_q <= ~sample;
      oe_q <= en;
    end
  end

  assign fb_out = fb_q;
  assign fb_oe  = oe_q;

  // R1: feedback is the inverse of the previous sample
  assert_fb_inverse_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fb_q == ~$past(sample));
  // R7: the output-enable follows en with one cycle of delay
  assert_oe_follows_en_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fb_oe == $past(en));
endmodule

// File: rtl/fsd_classifier.sv
module fsd_classifier
  import fsd_pkg::*;
#(
  parameter int LOOP_LAT = 3,
  parameter int RUN_LEN  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       sample,
  output logic       res_valid,
  output logic [1:0] res_code
);
  localparam int CNT_W  = $clog2(RUN_LEN + 1);
  localparam int FILL_W = $clog2(LOOP_LAT + 1);

  logic [LOOP_LAT-1:0] hist_q;
  logic [FILL_W-1:0]   fill_q;
  logic [CNT_W-1:0]    s_run_q, f_run_q, s_run_n, f_run_n;
  logic                valid_q;
  lvl_e                code_q;
  logic                filled, steady_ok, float_ok, steady_hit, float_hit;

  assign filled    = (fill_q == FILL_W'(LOOP_LAT));
  assign steady_ok = (sample == hist_q[0]);
  assign float_ok  = (sample != hist_q[LOOP_LAT-1]);

  always_comb begin
    s_run_n = '0;
    f_run_n = '0;
    if (en && filled && steady_ok)
      s_run_n = (s_run_q == CNT_W'(RUN_LEN)) ? s_run_q : s_run_q + 1'b1;
    if (en && filled && float_ok)
      f_run_n = (f_run_q == CNT_W'(RUN_LEN)) ? f_run_q : f_run_q + 1'b1;
  end

  assign steady_hit = (s_run_n >= CNT_W'(RUN_LEN));
  assign float_hit  = (f_run_n >= CNT_W'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hist_q  <= '0;
      fill_q  <= '0;
      s_run_q <= '0;
      f_run_q <= '0;
      valid_q <= 1'b0;
      code_q  <= LVL_LOW;
    end else begin
      hist_q  <= {hist_q[LOOP_LAT-2:0], sample};
      if (!filled) fill_q <= fill_q + 1'b1;
      s_run_q <= s_run_n;
      f_run_q <= f_run_n;
      valid_q <= steady_hit || float_hit;
      if (steady_hit)     code_q <= sample ? LVL_HIGH : LVL_LOW;
      else if (float_hit) code_q <= LVL_FLOAT;
    end
  end

  assign res_valid = valid_q;
  assign res_code  = code_q;

  initial begin
    assert_params_R5: assert (RUN_LEN > LOOP_LAT && LOOP_LAT >= 2);
  end

  // R7: disabled means invalid in the next cycle
  assert_invalid_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !res_valid);
  // R8: unused code is never reported
  assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_code != 2'b11);
  // R3: a floating report is backed by a full run
  assert_float_run_R3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == LVL_FLOAT) |-> f_run_q >= CNT_W'(RUN_LEN));
  // R4: a level report equals the sample it came from
  assert_level_match_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code != LVL_FLOAT) |-> res_code[0] == $past(sample));
  // R5: a valid result needs a full run in the previous cycle's counters
  assert_run_before_valid_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (s_run_q >= CNT_W'(RUN_LEN) || f_run_q >= CNT_W'(RUN_LEN)));
endmodule

// File: rtl/float_sense_top.sv
module float_sense_top #(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       pin_in,
  output logic       fb_out,
  output logic       fb_oe,
  output logic       res_valid,
  output logic [1:0] res_code
);
  localparam int LOOP_LAT = SYNC_STAGES + 1;

  logic sample;

  fsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(sample)
  );

  fsd_fb_drive u_fb (
    .clk(clk), .rst(rst), .en(en), .sample(sample),
    .fb_out(fb_out), .fb_oe(fb_oe)
  );

  fsd_classifier #(.LOOP_LAT(LOOP_LAT), .RUN_LEN(RUN_LEN)) u_cls (
    .clk(clk), .rst(rst), .en(en), .sample(sample),
    .res_valid(res_valid), .res_code(res_code)
  );
endmodule

// File: tb/tb_float_sense_top.sv
module tb_float_sense_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic pin_in, fb_out, fb_oe, res_valid;
  logic [1:0] res_code;
  int n_chk = 0, n_fail = 0;
  logic [1:0] mode = 2'd1;  // 0 low, 1 high, 2 floating, 3 irregular
  logic hold_q = 1'b0;
  logic [1:0] pat_idx = 2'd0;
  logic [3:0] pat = 4'b1011;  // read as 1,1,0,1 from index 0

  typedef struct { logic v; logic [1:0] c; string tag; } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  always #2 clk = ~clk;

  float_sense_top dut (
    .clk(clk), .rst(rst), .en(en), .pin_in(pin_in), .fb_out(fb_out),
    .fb_oe(fb_oe), .res_valid(res_valid), .res_code(res_code)
  );

  always_ff @(posedge clk) begin
    if (fb_oe) hold_q <= fb_out;
    pat_idx <= pat_idx + 2'd1;
  end

  always_comb begin
    case (mode)
      2'd0:    pin_in = 1'b0;
      2'd1:    pin_in = 1'b1;
      2'd2:    pin_in = fb_oe ? fb_out : hold_q;
      default: pin_in = pat[pat_idx];
    endcase
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_result(input logic v, input logic [1:0] c, input string tag);
    exp_t e;
    e.v = v; e.c = c; e.tag = tag;
    sb_q.push_back(e);
    -> chk_ev;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(res_valid == e.v, {e.tag, " valid"}, res_valid, e.v);
        check(res_code == e.c, {e.tag, " code"}, res_code, e.c);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin : driver
    int toggles, hits;
    logic prev;
    cycles(5);
    check(res_valid == 1'b0, "R7 reset valid", res_valid, 0);
    check(fb_oe == 1'b0, "R7 reset oe", fb_oe, 0);
    rst = 1'b0;
    cycles(30);
    check(res_valid == 1'b0, "R7 disabled valid", res_valid, 0);
    check(fb_oe == 1'b0, "R7 disabled oe", fb_oe, 0);

    en = 1'b1; mode = 2'd1;
    cycles(6);
    check(res_valid == 1'b0, "R5 early after enable", res_valid, 0);
    cycles(34);
    expect_result(1'b1, 2'b01, "R4 high");
    cycles(1);
    check(fb_out == 1'b0, "R1 fb for high", fb_out, 0);
    check(fb_oe == 1'b1, "R1 oe enabled", fb_oe, 1);

    mode = 2'd0;
    cycles(5);
    check(res_valid == 1'b0, "R6 break clears valid", res_valid, 0);
    cycles(35);
    expect_result(1'b1, 2'b00, "R4 low");
    cycles(1);
    check(fb_out == 1'b1, "R1 fb for low", fb_out, 1);

    mode = 2'd2;
    cycles(40);
    expect_result(1'b1, 2'b10, "R3 floating");
    toggles = 0; prev = fb_out;
    for (int i = 0; i < 24; i++) begin
      cycles(1);
      if (fb_out != prev) toggles++;
      prev = fb_out;
    end
    check(toggles >= 7 && toggles <= 9, "R2 loop toggles", toggles, 8);

    mode = 2'd1;
    cycles(40);
    expect_result(1'b1, 2'b01, "R4 float to high");

    mode = 2'd3;
    cycles(10);
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      cycles(1);
      if (res_valid) hits++;
    end
    check(hits == 0, "R6 irregular never valid", hits, 0);

    mode = 2'd2;
    cycles(40);
    expect_result(1'b1, 2'b10, "R3 floating again");
    cycles(1);
    en = 1'b0;
    cycles(3);
    check(res_valid == 1'b0, "R7 drop valid", res_valid, 0);
    check(fb_oe == 1'b0, "R7 drop oe", fb_oe, 0);
    check(res_code != 2'b11, "R8 code legal", res_code, 0);
    cycles(2);
    summary();
  end
endmodule